// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors each give a guess. The global component indexes a table of 2-bit saturating counters with a 12-bit shift register that holds the outcomes of the most recent branches. The local component keeps a 10-bit outcome history per branch slot and uses it to index a shared table of 3-bit saturating counters. A chooser table of 2-bit counters, indexed by the branch address, decides which of the two guesses becomes the final prediction.

A fetch stage presents a branch PC on the lookup port. In the same cycle it receives the final direction and both component guesses, and it keeps the component guesses with the branch. When the branch resolves, the back end presents the PC, the real outcome and the two kept guesses on the update port. One cycle then trains the chooser, both counter tables, the branch's local history and the global history. Lookup reads the stored state through combinational paths, so a lookup made in the same cycle as an update sees the tables as they were before that update.

Each chooser entry is a four-state machine: PICK_LOCAL_STRONG, PICK_LOCAL_WEAK, PICK_GLOBAL_WEAK and PICK_GLOBAL_STRONG. Each update produces a verdict: VERDICT_GLOBAL (only the global guess was right) moves the entry one state toward PICK_GLOBAL_STRONG. VERDICT_LOCAL (only the local guess was right) moves it one state toward PICK_LOCAL_STRONG. VERDICT_NONE (both guesses right or both wrong) leaves it in place. An entry already at an end state stays there.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every 2-bit counter holds 01, every 3-bit counter holds 011, every history holds zero, and every chooser entry is PICK_LOCAL_WEAK, so all three prediction outputs are 0.
- R2: A counter predicts taken exactly when its most significant bit is 1. A valid update with a taken outcome increments the addressed counter, and one with a not-taken outcome decrements it. Counters saturate at 0 and at all-ones.
- R3: The global guess comes from the 4096-entry 2-bit counter table indexed by the 12-bit global history alone, so every PC sees the same global guess.
- R4: A 2-bit global counter in its strongly-taken state still predicts taken after one not-taken training, and predicts not-taken after a second one.
- R5: Each valid update shifts the global history left by one bit and puts the outcome (1 = taken) into bit 0. The global counter that is trained is the one indexed by the history before the shift.
- R6: The local history table has 1024 entries of 10 bits, indexed by PC bits [11:2]. A valid update shifts the addressed entry left and puts the outcome into bit 0. PCs that differ only above bit 11 share an entry.
- R7: The local guess is the MSB of the 1024-entry 3-bit counter table, indexed by the lookup branch's local history. A valid update trains the counter indexed by the updated branch's history before the shift.
- R8: The chooser has 4096 entries indexed by PC bits [13:2]. In PICK_GLOBAL_WEAK or PICK_GLOBAL_STRONG the final prediction equals the global guess. In the other two states it equals the local guess.
- R9: The chooser entry of the update PC moves one state toward the global side when only the kept global guess matches the outcome, one state toward the local side when only the kept local guess matches, and stays put otherwise.
- R10: A lookup in the same cycle as an update returns the state before that update. The trained values are visible from the next cycle on.
- R11: With up_valid low, no table and no history changes, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | PC of the branch being predicted |
| pred_taken | output | 1 | Final direction (1 = taken) |
| pred_global | output | 1 | Guess of the global component |
| pred_local | output | 1 | Guess of the local component |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Real outcome (1 = taken) |
| up_pred_global | input | 1 | Global guess kept from lookup |
| up_pred_local | input | 1 | Local guess kept from lookup |

## Verification
Runs of twelve taken branches drive the global history to all ones. A not-taken branch followed by twelve taken ones then returns the history to the same counter. This shows whether one miss or two is needed to flip that counter, and whether the counter wraps instead of saturating. A single branch trained taken past the width of its local history does the same for the 3-bit counters. A second PC with an empty history tells a shared counter table apart from a per-branch one. Not-taken chooser trainings with each combination of kept guesses, observed once the global guess is taken and the local guess is not, separate every chooser transition. A lookup made in the same cycle as an update, and strobes with up_valid low, show the read-before-write order and the gating.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Chooser entry states, ordered so that counting up moves toward global.
    typedef enum logic [1:0] {
        PICK_LOCAL_STRONG  = 2'b00,
        PICK_LOCAL_WEAK    = 2'b01,
        PICK_GLOBAL_WEAK   = 2'b10,
        PICK_GLOBAL_STRONG = 2'b11
    } chooser_state_t;

    // Outcome of comparing the kept component guesses with the real outcome.
    typedef enum logic [1:0] {
        VERDICT_NONE   = 2'b00,
        VERDICT_GLOBAL = 2'b01,
        VERDICT_LOCAL  = 2'b10
    } verdict_t;

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] upd_cur;
    logic [CTR_W-1:0] upd_nxt;

    assign rd_ctr  = mem[rd_idx];
    assign upd_cur = mem[upd_idx];

    always_comb begin
        if (upd_up)
            upd_nxt = (upd_cur == CTR_MAX) ? upd_cur : upd_cur + 1'b1;
        else
            upd_nxt = (upd_cur == '0) ? upd_cur : upd_cur - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (upd_en) begin
            mem[upd_idx] <= upd_nxt;
        end
    end

    // Checker state: the entry addressed last cycle and its value then.
    logic [IDX_W-1:0] chk_idx;
    logic [CTR_W-1:0] chk_val;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_idx <= '0;
            chk_val <= CTR_INIT;
        end else begin
            chk_idx <= upd_idx;
            chk_val <= upd_cur;
        end
    end

    AST_CTR_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && upd_cur == CTR_MAX) |=> (mem[chk_idx] == CTR_MAX)); // R2
    AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_up && upd_cur == '0) |=> (mem[chk_idx] == '0)); // R2
    AST_CTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (mem[chk_idx] == chk_val)); // R11

endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic [IDX_W-1:0]  upd_idx,
    output logic [HIST_W-1:0] upd_hist,
    input  logic              upd_en,
    input  logic              upd_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist [DEPTH];

    assign rd_hist  = hist[rd_idx];
    assign upd_hist = hist[upd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (upd_en) begin
            hist[upd_idx] <= {upd_hist[HIST_W-2:0], upd_bit};
        end
    end

    logic [IDX_W-1:0] chk_idx;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_idx <= '0;
        else        chk_idx <= upd_idx;
    end

    AST_LHIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (hist[chk_idx][0] == $past(upd_bit))); // R6

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
    parameter int PC_W         = 32,
    parameter int PC_LSB       = 2,
    parameter int GHIST_W      = 12,
    parameter int CHOOSE_IDX_W = 12,
    parameter int LOCAL_IDX_W  = 10,
    parameter int LHIST_W      = 10,
    parameter int GCTR_W       = 2,
    parameter int LCTR_W       = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_pred_global,
    input  logic            up_pred_local
);
    import bp_pkg::*;

    localparam int CH_W = $bits(chooser_state_t);

    logic [CHOOSE_IDX_W-1:0] lk_ch_idx, up_ch_idx;
    logic [LOCAL_IDX_W-1:0]  lk_lh_idx, up_lh_idx;
    logic [GHIST_W-1:0]      ghist;
    logic [LHIST_W-1:0]      lk_lhist, up_lhist;
    logic [GCTR_W-1:0]       g_rd;
    logic [LCTR_W-1:0]       l_rd;
    logic [CH_W-1:0]         ch_rd;
    chooser_state_t          pick;
    verdict_t                verdict;
    logic                    ch_upd_en, ch_upd_up;
    logic                    unused_pc_bits;

    assign lk_ch_idx = lk_pc[PC_LSB +: CHOOSE_IDX_W];
    assign up_ch_idx = up_pc[PC_LSB +: CHOOSE_IDX_W];
    assign lk_lh_idx = lk_pc[PC_LSB +: LOCAL_IDX_W];
    assign up_lh_idx = up_pc[PC_LSB +: LOCAL_IDX_W];
    assign unused_pc_bits = ^{lk_pc, up_pc};

    // Global history register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ghist <= '0;
        else if (up_valid) ghist <= {ghist[GHIST_W-2:0], up_taken};
    end

    bp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_global_ctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist), .rd_ctr(g_rd),
        .upd_en(up_valid), .upd_idx(ghist), .upd_up(up_taken)
    );

    bp_hist_table #(.IDX_W(LOCAL_IDX_W), .HIST_W(LHIST_W)) u_local_hist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_lh_idx), .rd_hist(lk_lhist),
        .upd_idx(up_lh_idx), .upd_hist(up_lhist),
        .upd_en(up_valid), .upd_bit(up_taken)
    );

    bp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_local_ctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_lhist), .rd_ctr(l_rd),
        .upd_en(up_valid), .upd_idx(up_lhist), .upd_up(up_taken)
    );

    bp_ctr_table #(.IDX_W(CHOOSE_IDX_W), .CTR_W(CH_W)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_ch_idx), .rd_ctr(ch_rd),
        .upd_en(ch_upd_en), .upd_idx(up_ch_idx), .upd_up(ch_upd_up)
    );

    assign pred_global = g_rd[GCTR_W-1];
    assign pred_local  = l_rd[LCTR_W-1];
    assign pick        = chooser_state_t'(ch_rd);

    // Output select from the chooser state.
    always_comb begin
        unique case (pick)
            PICK_GLOBAL_STRONG, PICK_GLOBAL_WEAK: pred_taken = pred_global;
            PICK_LOCAL_WEAK, PICK_LOCAL_STRONG:   pred_taken = pred_local;
        endcase
    end

    // Chooser transition from the pair of correctness results.
    always_comb begin
        unique case ({up_pred_global == up_taken, up_pred_local == up_taken})
            2'b10:   verdict = VERDICT_GLOBAL;
            2'b01:   verdict = VERDICT_LOCAL;
            default: verdict = VERDICT_NONE;
        endcase
    end

    assign ch_upd_en = up_valid && (verdict != VERDICT_NONE);
    assign ch_upd_up = (verdict == VERDICT_GLOBAL);

    AST_GHIST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist)); // R11
    AST_GHIST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> (ghist[0] == $past(up_taken))); // R5

endmodule

// File: tb/tournament_bp_test.sv
module tournament_bp_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_taken, pred_global, pred_local;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        up_pred_global = 1'b0;
    logic        up_pred_local = 1'b0;

    int checks = 0;
    int errors = 0;

    tournament_bp uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_pred_global(up_pred_global), .up_pred_local(up_pred_local)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic actual, input logic expected, input string tag);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        up_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sets the lookup PC and waits for the combinational read to settle.
    task automatic look(input logic [31:0] pc);
        lk_pc = pc;
        #1;
    endtask

    // One update cycle; returns at the following falling edge.
    task automatic train(input logic [31:0] pc, input logic tk,
                         input logic pg, input logic pl);
        @(negedge clk);
        up_pc = pc; up_taken = tk; up_pred_global = pg; up_pred_local = pl;
        up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic train_run(input logic [31:0] pc, input logic tk, input int n);
        for (int i = 0; i < n; i++) train(pc, tk, tk, tk);
    endtask

    task automatic test_reset();
        apply_reset();
        @(negedge clk);
        foreach (lk_pc[i]) begin end
        look(32'h0000_0000);
        check(pred_global, 1'b0, "R1 global after reset");
        check(pred_local,  1'b0, "R1 local after reset");
        check(pred_taken,  1'b0, "R1 final after reset");
        look(32'h0000_3FFC);
        check(pred_taken,  1'b0, "R1 final after reset, high index");
    endtask

    task automatic test_global();
        logic [31:0] p = 32'h0000_0200;
        apply_reset();
        train_run(p, 1'b1, 12);                // history now all ones
        look(p);
        check(pred_global, 1'b0, "R3 all-ones entry still weak not-taken");
        // Strobes with up_valid low must not train anything.
        @(negedge clk);
        up_pc = p; up_taken = 1'b1; up_pred_global = 1'b0; up_pred_local = 1'b1;
        up_valid = 1'b0;
        repeat (3) @(negedge clk);
        look(p);
        check(pred_global, 1'b0, "R11 no training without up_valid");
        train_run(p, 1'b1, 1);
        look(p);
        check(pred_global, 1'b1, "R2 counter 10 predicts taken");
        look(32'h0000_07FC);
        check(pred_global, 1'b1, "R3 same global guess for another PC");
        train_run(p, 1'b1, 3);                 // saturate at 11
        train_run(p, 1'b0, 1);                 // history 0xFFE, counter 11->10
        look(p);
        check(pred_global, 1'b0, "R5 outcome 0 shifted into history bit 0");
        train_run(p, 1'b1, 12);
        look(p);
        check(pred_global, 1'b1, "R4 one miss keeps taken (and R2 saturation)");
        train_run(p, 1'b0, 1);
        train_run(p, 1'b1, 12);
        look(p);
        check(pred_global, 1'b0, "R4 second miss flips to not-taken");
    endtask

    task automatic test_local();
        logic [31:0] p = 32'h0000_0044;
        apply_reset();
        train_run(p, 1'b1, 10);                // local history 0x3FF
        look(p);
        check(pred_local, 1'b0, "R7 counter at all-ones history still 011");
        look(32'h0000_0088);
        check(pred_local, 1'b1, "R7 empty history reads shared counter 100");
        train_run(p, 1'b1, 1);
        look(p);
        check(pred_local,  1'b1, "R2 3-bit counter 100 predicts taken");
        check(pred_global, 1'b0, "R3 global guess not-taken here");
        check(pred_taken,  1'b1, "R8 weak-local chooser passes local guess");
        train_run(p, 1'b1, 5);                 // 101,110,111,111,111
        for (int r = 1; r <= 4; r++) begin
            train_run(p, 1'b0, 1);
            if (r == 1) begin
                look(p);
                check(pred_local, 1'b0, "R6 outcome 0 shifted into local history");
            end
            train_run(p, 1'b1, 10);
            look(p);
            check(pred_local, (r < 4), "R2 3-bit saturation and count-down");
            if (r == 3) begin
                look(p + 32'h0000_1000);
                check(pred_local, 1'b1, "R6 PC bits above 11 share the history");
            end
        end
    endtask

    task automatic test_chooser();
        logic [31:0] pc_c = 32'h0000_0010;
        logic [31:0] pc_e = 32'h0000_0020;
        logic [31:0] pc_f = 32'h0000_0030;
        logic [31:0] pc_g = 32'h0000_0040;
        logic [31:0] pc_h = 32'h0000_0050;
        logic [31:0] pc_d = 32'h0000_0060;
        apply_reset();
        // All not-taken: histories stay zero, only choosers differ.
        train(pc_c, 1'b0, 1'b0, 1'b1);         // global right: weak-global
        train(pc_e, 1'b0, 1'b1, 1'b1);         // both wrong: stays
        train(pc_f, 1'b0, 1'b0, 1'b0);         // both right: stays
        train(pc_g, 1'b0, 1'b0, 1'b1);
        train(pc_g, 1'b0, 1'b0, 1'b1);         // strong-global
        train(pc_g, 1'b0, 1'b1, 1'b0);         // back to weak-global
        train(pc_h, 1'b0, 1'b0, 1'b1);         // weak-global
        train(pc_h, 1'b0, 1'b1, 1'b0);         // weak-local
        train_run(pc_d, 1'b1, 12);             // global history all ones
        // Same-cycle lookup during the 13th update.
        @(negedge clk);
        up_pc = pc_d; up_taken = 1'b1; up_pred_global = 1'b1; up_pred_local = 1'b1;
        up_valid = 1'b1;
        look(pc_c);
        check(pred_global, 1'b0, "R10 lookup in update cycle sees old counter");
        @(negedge clk);
        up_valid = 1'b0;
        look(pc_c);
        check(pred_global, 1'b1, "R10 trained counter visible next cycle");
        check(pred_local,  1'b0, "R7 empty history counter is not-taken");
        check(pred_taken,  1'b1, "R9 global-only-right moves toward global");
        look(pc_e);
        check(pred_taken,  1'b0, "R9 both wrong leaves chooser");
        look(pc_f);
        check(pred_taken,  1'b0, "R9 both right leaves chooser");
        look(pc_g);
        check(pred_taken,  1'b1, "R9 strong-global needs two local wins");
        look(pc_h);
        check(pred_taken,  1'b0, "R9 local-only-right moves toward local");
        look(pc_d);
        check(pred_local,  1'b1, "R7 trained local counter");
        look(pc_c + 32'h0000_4000);
        check(pred_taken,  1'b1, "R8 chooser indexed by PC bits 13:2");
    endtask

    initial begin
        test_reset();
        test_global();
        test_local();
        test_chooser();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule